// File: doc/BRIEF.md
# Modified Immediate Encoder

This block decides whether a 32-bit constant fits the 12-bit modified immediate field of a 32-bit instruction encoding. When it fits, the block returns the 12-bit code. A code generator or an assembler datapath would use it to pick between a single-instruction constant load and a longer sequence.

Two families of forms are tried, in a fixed order. The first is byte replication. Here the code keeps one payload byte B in bits 7:0 and a 4-bit replication selector in bits 11:8. The selector can mean that B stands alone, that B sits in bytes 0 and 2, that B sits in bytes 1 and 3, or that B fills all four bytes. The second is a rotated window: all set bits lie within the eight bits that start at the most significant set bit. Here bits 11:7 give the leading-zero count plus eight, and bits 6:0 give the seven window bits below the leading one. That leading one is implied and is not stored.

Inputs arrive on a valid/ready handshake whose ready is always high. The encoder accepts one value every cycle. Each result appears on a registered output exactly one cycle later, together with an encodable flag.

Top module: `mimm_enc`

## Requirements
- R1: An input whose bits 31:8 are all zero is encodable, and its code is the input value itself with bits 11:8 equal to 0.
- R2: An input with a nonzero low byte B, B again in byte 2, and zero in bytes 1 and 3 encodes as 0x100 | B.
- R3: An input with a zero low byte, a byte B in bytes 1 and 3, and zero in byte 2 encodes as 0x200 | B.
- R4: An input whose four bytes all equal one nonzero byte B encodes as 0x300 | B.
- R5: An input that matches no replication form encodes in the rotated form when every set bit lies in the 8-bit window that begins at its most significant set bit and the leading-zero count L is below 24. The code then has bits 11:7 = L + 8 and bits 6:0 = the seven bits just below the leading one.
- R6: An input that fits no form gives out_ok = 0 and out_code = 0.
- R7: A zero input gives out_ok = 1 and out_code = 0.
- R8: in_ready is always 1. out_valid in a cycle equals in_valid of the previous cycle.
- R9: While in_valid is low, out_ok and out_code keep their last values.
- R10: While reset is asserted (rst_n low), out_valid, out_ok and out_code are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input value present |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_value | input | 32 | Constant to encode |
| out_valid | output | 1 | Result present, one cycle after in_valid |
| out_ok | output | 1 | Value has a 12-bit encoding |
| out_code | output | 12 | The 12-bit encoding, 0 when not encodable |

## Verification
The bench builds the encoder with its default byte width of 8, which gives a 32-bit word and a 12-bit code. At that width every replication selector can be reached, and so can the rotation field across its whole range, from leading-zero count 0 (field 8) to count 23 (field 31). The same width brings within reach the near misses that must be rejected: a bit just outside the window, a replication pattern with one byte wrong, and a value with all bytes different.

// File: rtl/mimm_pkg.sv
package mimm_pkg;

    // Which form produced the registered result.
    typedef enum logic [1:0] {
        FORM_NONE  = 2'd0,
        FORM_SPLAT = 2'd1,
        FORM_ROT   = 2'd2
    } mimm_form_e;

    // Replication selector values placed above the payload byte.
    localparam logic [1:0] SEL_ALONE = 2'd0;
    localparam logic [1:0] SEL_EVEN  = 2'd1;
    localparam logic [1:0] SEL_ODD   = 2'd2;
    localparam logic [1:0] SEL_ALL   = 2'd3;

endpackage

// File: rtl/mimm_lzc.sv
module mimm_lzc #(
    parameter int WORD_W = 32,
    localparam int LZ_W  = $clog2(WORD_W + 1)
) (
    input  logic [WORD_W-1:0] value,
    output logic [LZ_W-1:0]   lz
);

    // Scan from the least significant bit upward; the last hit is the MSB.
    always_comb begin
        lz = LZ_W'(WORD_W);
        for (int i = 0; i < WORD_W; i++) begin
            if (value[i]) begin
                lz = LZ_W'(WORD_W - 1 - i);
            end
        end
    end

endmodule

// File: rtl/mimm_splat.sv
module mimm_splat
    import mimm_pkg::*;
#(
    parameter int BYTE_W   = 8,
    localparam int WORD_W  = 4 * BYTE_W,
    localparam int LANES   = 4
) (
    input  logic [WORD_W-1:0] value,
    output logic              hit,
    output logic [1:0]        sel,
    output logic [BYTE_W-1:0] payload
);

    logic [BYTE_W-1:0] lane [LANES];
    logic              low_zero;
    logic [WORD_W-1:0] aligned;
    logic [BYTE_W-1:0] pb;
    logic [WORD_W-1:0] pair_pat;
    logic              all_same;
    logic              upper_zero;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = value[g*BYTE_W +: BYTE_W];
    end

    always_comb begin
        upper_zero = (value[WORD_W-1:BYTE_W] == '0);
        low_zero   = (lane[0] == '0);
        aligned    = low_zero ? (value >> BYTE_W) : value;
        pb         = aligned[BYTE_W-1:0];
        pair_pat   = {{BYTE_W{1'b0}}, pb, {BYTE_W{1'b0}}, pb};
        all_same   = 1'b1;
        for (int k = 1; k < LANES; k++) begin
            if (lane[k] != lane[0]) begin
                all_same = 1'b0;
            end
        end

        hit     = 1'b0;
        sel     = SEL_ALONE;
        payload = pb;
        if (upper_zero) begin
            hit     = 1'b1;
            sel     = SEL_ALONE;
            payload = lane[0];
        end else if (aligned == pair_pat) begin
            hit = 1'b1;
            sel = low_zero ? SEL_ODD : SEL_EVEN;
        end else if (all_same) begin
            hit = 1'b1;
            sel = SEL_ALL;
        end
    end

endmodule

// File: rtl/mimm_rotate.sv
module mimm_rotate #(
    parameter int BYTE_W    = 8,
    localparam int WORD_W   = 4 * BYTE_W,
    localparam int LZ_W     = $clog2(WORD_W + 1),
    localparam int FIELD_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0]  value,
    output logic               hit,
    output logic [FIELD_W-1:0] field,
    output logic [BYTE_W-2:0]  payload
);

    logic [LZ_W-1:0]   lz;
    logic [WORD_W-1:0] below_window;
    logic [WORD_W-1:0] past_lead;

    mimm_lzc #(.WORD_W(WORD_W)) lzc_i (
        .value (value),
        .lz    (lz)
    );

    always_comb begin
        // Bits under the window: shift out leading zeros plus the window itself.
        below_window = value << (32'(lz) + BYTE_W);
        // Drop leading zeros and the implied leading one; the next bits are payload.
        past_lead    = value << (32'(lz) + 1);
        hit          = (32'(lz) < WORD_W - BYTE_W) && (below_window == '0);
        field        = FIELD_W'(32'(lz) + BYTE_W);
        payload      = past_lead[WORD_W-1 -: BYTE_W-1];
    end

endmodule

// File: rtl/mimm_enc.sv
module mimm_enc
    import mimm_pkg::*;
#(
    parameter int BYTE_W    = 8,
    localparam int WORD_W   = 4 * BYTE_W,
    localparam int FIELD_W  = $clog2(WORD_W),
    localparam int CODE_W   = BYTE_W - 1 + FIELD_W,
    localparam int SEL_W    = CODE_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_value,
    output logic              out_valid,
    output logic              out_ok,
    output logic [CODE_W-1:0] out_code
);

    typedef struct packed {
        logic              valid;
        logic              ok;
        logic [CODE_W-1:0] code;
    } enc_state_t;

    enc_state_t st_d, st_q;

    logic               sp_hit;
    logic [1:0]         sp_sel;
    logic [BYTE_W-1:0]  sp_byte;
    logic               rt_hit;
    logic [FIELD_W-1:0] rt_field;
    logic [BYTE_W-2:0]  rt_payload;
    mimm_form_e         form;

    mimm_splat #(.BYTE_W(BYTE_W)) splat_i (
        .value   (in_value),
        .hit     (sp_hit),
        .sel     (sp_sel),
        .payload (sp_byte)
    );

    mimm_rotate #(.BYTE_W(BYTE_W)) rot_i (
        .value   (in_value),
        .hit     (rt_hit),
        .field   (rt_field),
        .payload (rt_payload)
    );

    always_comb begin
        // Replication forms win over the rotated window.
        if (sp_hit) begin
            form = FORM_SPLAT;
        end else if (rt_hit) begin
            form = FORM_ROT;
        end else begin
            form = FORM_NONE;
        end

        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            unique case (form)
                FORM_SPLAT: begin
                    st_d.ok   = 1'b1;
                    st_d.code = {SEL_W'(sp_sel), sp_byte};
                end
                FORM_ROT: begin
                    st_d.ok   = 1'b1;
                    st_d.code = {rt_field, rt_payload};
                end
                default: begin
                    st_d.ok   = 1'b0;
                    st_d.code = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign in_ready  = 1'b1;
    assign out_valid = st_q.valid;
    assign out_ok    = st_q.ok;
    assign out_code  = st_q.code;

endmodule

// File: rtl/mimm_enc_chk.sv
module mimm_enc_chk #(
    parameter int BYTE_W    = 8,
    localparam int WORD_W   = 4 * BYTE_W,
    localparam int CODE_W   = BYTE_W - 1 + $clog2(WORD_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_value,
    input logic              out_valid,
    input logic              out_ok,
    input logic [CODE_W-1:0] out_code
);

    // R8: output valid trails input valid by one cycle
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R9: result held while no new input
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_ok) && $stable(out_code)));

    // R6: a rejected value never shows a stale code
    assert_reject_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ok |-> (out_code == '0));

    // R1: small values pass straight through
    assert_plain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_value[WORD_W-1:BYTE_W] == '0)) |=>
        (out_ok && (out_code == CODE_W'($past(in_value[BYTE_W-1:0])))));

    // R4: full replication selects code 3
    assert_quad_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (in_value == {4{in_value[BYTE_W-1:0]}}) &&
         (in_value[BYTE_W-1:0] != '0)) |=>
        (out_ok && (out_code[CODE_W-1:BYTE_W] == 3)));

endmodule

bind mimm_enc mimm_enc_chk #(.BYTE_W(BYTE_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_value  (in_value),
    .out_valid (out_valid),
    .out_ok    (out_ok),
    .out_code  (out_code)
);

// File: tb/mimm_enc_tb.sv
module mimm_enc_tb_top;

    localparam int NV = 18;

    // {value, encodable, code}
    localparam logic [44:0] VEC [NV] = '{
        {32'h0000_0000, 1'b1, 12'h000},
        {32'h0000_00AB, 1'b1, 12'h0AB},
        {32'h00AB_00AB, 1'b1, 12'h1AB},
        {32'hAB00_AB00, 1'b1, 12'h2AB},
        {32'hABAB_ABAB, 1'b1, 12'h3AB},
        {32'hFFFF_FFFF, 1'b1, 12'h3FF},
        {32'h0000_0100, 1'b1, 12'hF80},
        {32'hFF00_0000, 1'b1, 12'h47F},
        {32'h8000_0000, 1'b1, 12'h400},
        {32'h00FF_0000, 1'b1, 12'h87F},
        {32'h0003_FC00, 1'b1, 12'hB7F},
        {32'h0000_01FE, 1'b1, 12'hFFF},
        {32'h0000_8000, 1'b1, 12'hC00},
        {32'h0000_0180, 1'b1, 12'hFC0},
        {32'h0000_0101, 1'b0, 12'h000},
        {32'h0102_0304, 1'b0, 12'h000},
        {32'h00AB_00AC, 1'b0, 12'h000},
        {32'h8000_0001, 1'b0, 12'h000}
    };
    localparam string TAG [NV] = '{
        "R7", "R1", "R2", "R3", "R4", "R4", "R5", "R5", "R5",
        "R5", "R5", "R5", "R5", "R5", "R6", "R6", "R6", "R6"
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_value = '0;
    logic        out_valid;
    logic        out_ok;
    logic [11:0] out_code;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mimm_enc dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_value  (in_value),
        .out_valid (out_valid),
        .out_ok    (out_ok),
        .out_code  (out_code)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got=%h exp=%h", tag, what, got, exp);
        end
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: got=running exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", "valid in reset", 32'(out_valid), 32'd0);
        check("R10", "ok in reset", 32'(out_ok), 32'd0);
        check("R10", "code in reset", 32'(out_code), 32'd0);
        check("R8", "ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one value per cycle, result sampled one cycle later
        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_value = VEC[i][44:13];
            @(negedge clk);
            check(TAG[i], "valid", 32'(out_valid), 32'd1);
            check(TAG[i], $sformatf("ok for %h", VEC[i][44:13]),
                  32'(out_ok), 32'(VEC[i][12]));
            check(TAG[i], $sformatf("code for %h", VEC[i][44:13]),
                  32'(out_code), 32'(VEC[i][11:0]));
        end

        // R9: hold while idle, R8: valid drops one cycle after input
        in_valid = 1'b1;
        in_value = 32'h0000_00AB;
        @(negedge clk);
        in_valid = 1'b0;
        in_value = 32'h0102_0304;
        @(negedge clk);
        check("R8", "valid after idle", 32'(out_valid), 32'd0);
        @(negedge clk);
        check("R9", "ok held", 32'(out_ok), 32'd1);
        check("R9", "code held", 32'(out_code), 32'h0AB);

        // R8: a single-cycle pulse gives a single-cycle result
        in_valid = 1'b1;
        in_value = 32'h0102_0304;
        check("R8", "no early valid", 32'(out_valid), 32'd0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "pulse valid", 32'(out_valid), 32'd1);
        check("R6", "pulse reject ok", 32'(out_ok), 32'd0);
        check("R6", "pulse reject code", 32'(out_code), 32'd0);
        @(negedge clk);
        check("R8", "pulse valid gone", 32'(out_valid), 32'd0);

        // R10: reset mid-stream clears a held result
        in_valid = 1'b1;
        in_value = 32'hFF00_0000;
        @(negedge clk);
        check("R5", "before reset", 32'(out_code), 32'h47F);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10", "valid cleared", 32'(out_valid), 32'd0);
        check("R10", "ok cleared", 32'(out_ok), 32'd0);
        check("R10", "code cleared", 32'(out_code), 32'd0);
        in_valid = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule